// File: doc/BRIEF.md
# Indexed-Access Vectored Interrupt Controller

This block gathers up to 128 interrupt inputs and presents one interrupt request line to a processor. Each source has a priority, a trigger type, a stored vector, an enable bit and a pending flag. None of this per-source state is laid out as one bit per source in wide registers. Software first writes a source index into a select register. It then reads or writes that source's mode and vector, or issues single-word enable, disable, set-pending and clear-pending commands that act on the selected source.

Software services an interrupt by reading the vector register. That read returns the stored vector of the best pending, enabled source and acknowledges it. The source's priority and number go onto an eight-deep nesting stack. While that level is active, only a source of strictly higher priority can raise the request line again. Each write to the end-of-interrupt register pops one level. A vector read made when nothing qualifies returns a programmable spurious vector and changes no state.

Top module: `vec_intc`

## Requirements
- R1: The low 7 bits written to the select register (0x00) choose the source. The mode register (0x04) and the vector register (0x08) read and write the selected source only. Within the mode word, bits [2:0] hold the priority, where 7 is the highest, and bits [6:5] hold the trigger type. All other mode bits read as zero.
- R2: Writing a word with bit 0 set to 0x40 enables the selected source, and doing the same at 0x44 disables it. Bit 0 of the mask register (0x30) shows the selected source's enable bit. A source that is pending but disabled never raises the request line.
- R3: A write with bit 0 set to 0x4C makes the selected source pending, and the same write to 0x48 clears it. Clear takes precedence over a trigger event in the same cycle. Source n is pending bit n%32 of the word at 0x20 + 4*(n/32).
- R4: The trigger type has four encodings: 00 is level-low, 01 is falling edge, 10 is level-high and 11 is rising edge. An edge sets the pending flag once. A level sets it on every cycle the input is at the active level, and the flag stays set until it is cleared.
- R5: The request line `irq_o` is high when a pending, enabled source exists whose priority is above the top of the nesting stack, or when such a source exists and the stack is empty.
- R6: Among qualifying sources, the one with the highest priority wins, and on a tie the lowest source number wins. A vector read (0x10) returns the winner's stored vector.
- R7: A vector read made while `irq_o` is high pushes the winner onto the stack and clears the winner's pending flag if it is edge-triggered, but not if it is level-triggered. The status register (0x18) then returns the current source number. The request line stays low until a strictly higher-priority source qualifies or a level is popped.
- R8: A vector read made while `irq_o` is low returns the spurious register (0x3C), which can be read and written, and changes no state.
- R9: Any write to 0x38 pops one nesting level and does nothing when the stack is empty. After eight such writes the controller is idle, and status reads 0.
- R10: After reset, `irq_o` is low, no source is enabled or pending while its input is inactive, all modes are 0, the spurious vector is 0 and status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC | Interrupt source inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on 0x10) |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | VW | Write data |
| bus_rdata | output | VW | Read data, valid in the cycle of the read |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest state to reach is a completely full nesting stack. Reaching it takes eight sources with distinct priorities, each acknowledged while the previous level is still open, so their pending flags must be raised in strictly rising priority order. The bench gives eight sources priorities 0 to 7 and sets them pending one after another with the set command, acknowledging each one in turn. It then confirms that the request line stays low at the top level, and it unwinds all eight levels with end-of-interrupt writes. Tie-breaking by source number, and the case where a level-triggered source survives its acknowledge, are reached by arranging two equal-priority sources and by holding a level input active across the acknowledge.

// File: rtl/vec_intc.sv
module vec_intc #(
  parameter int NSRC  = 128,
  parameter int PW    = 3,
  parameter int VW    = 32,
  parameter int DEPTH = 8,
  parameter int AW    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [VW-1:0]   bus_wdata,
  output logic [VW-1:0]   bus_rdata,
  output logic            irq_o
);
  localparam int SW    = $clog2(NSRC);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int IW    = $clog2(DEPTH);
  localparam int NWORD = (NSRC + 31) / 32;

  logic [SW-1:0]    sel;
  logic [PW-1:0]    prio   [NSRC];
  logic [1:0]       typ    [NSRC];
  logic [VW-1:0]    vect   [NSRC];
  logic [NSRC-1:0]  en, pend, src_q, ev;
  logic [VW-1:0]    spur;
  logic [PW-1:0]    stk_pr [DEPTH];
  logic [SW-1:0]    stk_src[DEPTH];
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    tidx;
  logic             win_ok;
  logic [SW-1:0]    win_idx;
  logic [PW-1:0]    win_pr;
  logic [NWORD*32-1:0] pend_pad;

  wire wr_sel  = bus_wr && bus_addr == AW'(8'h00);
  wire wr_mode = bus_wr && bus_addr == AW'(8'h04);
  wire wr_vec  = bus_wr && bus_addr == AW'(8'h08);
  wire eoi_hit = bus_wr && bus_addr == AW'(8'h38);
  wire wr_spur = bus_wr && bus_addr == AW'(8'h3C);
  wire en_hit  = bus_wr && bus_addr == AW'(8'h40) && bus_wdata[0];
  wire dis_hit = bus_wr && bus_addr == AW'(8'h44) && bus_wdata[0];
  wire clr_hit = bus_wr && bus_addr == AW'(8'h48) && bus_wdata[0];
  wire set_hit = bus_wr && bus_addr == AW'(8'h4C) && bus_wdata[0];

  assign tidx     = IW'(cnt - CW'(1));
  assign irq_o    = win_ok && (cnt == '0 || win_pr > stk_pr[tidx]);
  wire   ack      = bus_rd && bus_addr == AW'(8'h10) && irq_o;
  assign pend_pad = (NWORD*32)'(pend);

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      case (typ[i])
        2'b00:   ev[i] = ~src_i[i];
        2'b01:   ev[i] = src_q[i] & ~src_i[i];
        2'b10:   ev[i] = src_i[i];
        default: ev[i] = ~src_q[i] & src_i[i];
      endcase
  end

  always_comb begin
    win_ok  = 1'b0;
    win_idx = '0;
    win_pr  = '0;
    for (int i = 0; i < NSRC; i++)
      if (pend[i] && en[i] && (!win_ok || prio[i] > win_pr)) begin
        win_ok  = 1'b1;
        win_idx = SW'(i);
        win_pr  = prio[i];
      end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(8'h00): bus_rdata[SW-1:0] = sel;
      AW'(8'h04): begin
        bus_rdata[PW-1:0] = prio[sel];
        bus_rdata[6:5]    = typ[sel];
      end
      AW'(8'h08): bus_rdata = vect[sel];
      AW'(8'h10): bus_rdata = irq_o ? vect[win_idx] : spur;
      AW'(8'h18): if (cnt != '0) bus_rdata[SW-1:0] = stk_src[tidx];
      AW'(8'h20), AW'(8'h24), AW'(8'h28), AW'(8'h2C):
        if (int'(bus_addr[3:2]) < NWORD) bus_rdata[31:0] = pend_pad[int'(bus_addr[3:2])*32 +: 32];
      AW'(8'h30): bus_rdata[0] = en[sel];
      AW'(8'h3C): bus_rdata = spur;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel   <= '0;
      spur  <= '0;
      en    <= '0;
      pend  <= '0;
      src_q <= '0;
      cnt   <= '0;
      for (int i = 0; i < NSRC; i++) begin
        prio[i] <= '0;
        typ[i]  <= '0;
        vect[i] <= '0;
      end
      for (int k = 0; k < DEPTH; k++) begin
        stk_pr[k]  <= '0;
        stk_src[k] <= '0;
      end
    end else begin
      src_q <= src_i;
      if (wr_sel)  sel  <= bus_wdata[SW-1:0];
      if (wr_spur) spur <= bus_wdata;
      if (wr_mode) begin
        prio[sel] <= bus_wdata[PW-1:0];
        typ[sel]  <= bus_wdata[6:5];
      end
      if (wr_vec) vect[sel] <= bus_wdata;
      if (en_hit)  en[sel] <= 1'b1;
      if (dis_hit) en[sel] <= 1'b0;
      for (int i = 0; i < NSRC; i++)
        if (clr_hit && sel == SW'(i))
          pend[i] <= 1'b0;
        else if (ack && win_idx == SW'(i) && typ[i][0])
          pend[i] <= 1'b0;
        else if (ev[i] || (set_hit && sel == SW'(i)))
          pend[i] <= 1'b1;
      if (ack) begin
        stk_pr[IW'(cnt)]  <= win_pr;
        stk_src[IW'(cnt)] <= win_idx;
        cnt <= cnt + CW'(1);
      end else if (eoi_hit && cnt != '0) begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r5_room_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> cnt < CW'(DEPTH));
  a_r7_ack_pushes: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> cnt == CW'($past(cnt) + CW'(1)));
  a_r9_eoi_pops: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && !ack && cnt != '0) |=> cnt == CW'($past(cnt) - CW'(1)));
  a_r2_disable_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    dis_hit |=> !en[$past(sel)]);
  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> !pend[$past(sel)]);
endmodule

// File: tb/test_vec_intc.sv
module test_vec_intc;
  localparam int NSRC = 128;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] src_i = '1;
  logic bus_wr = 1'b0, bus_rd = 1'b0, want_irq = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_o;
  int checks = 0, errors = 0;
  bit done = 0;

  int          q_kind[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  vec_intc i_vec_intc (.clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (bus_rd || want_irq) begin
      logic [31:0] got;
      got = (q_kind[0] == 1) ? {31'b0, irq_o} : bus_rdata;
      checks++;
      if (got !== q_exp[0]) begin
        errors++;
        $display("FAIL %s got %h expected %h", q_tag[0], got, q_exp[0]);
      end
      void'(q_kind.pop_front()); void'(q_exp.pop_front()); void'(q_tag.pop_front());
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    bus_wr = 0; bus_rd = 0; want_irq = 0;
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    tick(); bus_wr = 1; bus_addr = a; bus_wdata = d;
  endtask
  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    tick(); bus_rd = 1; bus_addr = a;
    q_kind.push_back(0); q_exp.push_back(e); q_tag.push_back(t);
  endtask
  task automatic irqchk(input logic e, input string t);
    tick(); want_irq = 1;
    q_kind.push_back(1); q_exp.push_back({31'b0, e}); q_tag.push_back(t);
  endtask
  task automatic cfg(input int s, input logic [7:0] m);
    wr(8'h00, s); wr(8'h04, m); wr(8'h08, 32'h1000 + s); wr(8'h40, 1);
  endtask
  task automatic cmd(input int s, input logic [7:0] a);
    wr(8'h00, s); wr(a, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired got hang expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    irqchk(0, "R10 irq low after reset");
    rd(8'h20, 0, "R10 no pending after reset");
    rd(8'h10, 0, "R10 spurious zero after reset");
    rd(8'h18, 0, "R10 status zero after reset");
    wr(8'h3C, 32'hDEAD);
    rd(8'h10, 32'hDEAD, "R8 spurious vector when idle");
    wr(8'h00, 5); wr(8'h04, 8'h63); wr(8'h08, 32'h1005);
    wr(8'h00, 6); wr(8'h04, 8'h63); wr(8'h08, 32'h1006); wr(8'h40, 1);
    wr(8'h00, 9); wr(8'h04, 8'hFF);
    rd(8'h04, 8'h67, "R1 mode fields masked");
    wr(8'h00, 5);
    rd(8'h04, 8'h63, "R1 mode of selected source");
    rd(8'h08, 32'h1005, "R1 vector of selected source");
    wr(8'h40, 1); rd(8'h30, 1, "R2 enable shows in mask");
    wr(8'h44, 1); rd(8'h30, 0, "R2 disable shows in mask");
    wr(8'h40, 1);
    tick(); src_i[5] = 0; tick(); src_i[5] = 1;
    rd(8'h20, 32'h20, "R4 rising edge sets pending once");
    irqchk(1, "R5 request for enabled pending");
    rd(8'h10, 32'h1005, "R6 vector of winner");
    irqchk(0, "R7 request drops after acknowledge");
    rd(8'h20, 0, "R7 edge pending cleared by acknowledge");
    rd(8'h18, 5, "R7 status shows current source");
    cmd(6, 8'h4C);
    rd(8'h20, 32'h40, "R3 set command makes pending");
    irqchk(0, "R7 equal priority does not preempt");
    rd(8'h10, 32'hDEAD, "R8 spurious when nothing above level");
    rd(8'h18, 5, "R8 spurious read changes no state");
    wr(8'h00, 9); wr(8'h04, 8'h45); wr(8'h08, 32'h1009); wr(8'h40, 1);
    irqchk(1, "R5 higher priority preempts");
    rd(8'h10, 32'h1009, "R6 higher priority vector");
    rd(8'h18, 9, "R7 status nested source");
    rd(8'h20, 32'h240, "R7 level pending survives acknowledge");
    tick(); src_i[9] = 0;
    cmd(9, 8'h48);
    rd(8'h20, 32'h40, "R3 clear command");
    wr(8'h38, 0);
    rd(8'h18, 5, "R9 eoi pops to previous level");
    irqchk(0, "R5 equal priority still blocked");
    wr(8'h38, 0);
    irqchk(1, "R9 idle after last pop");
    rd(8'h10, 32'h1006, "R6 pending source served");
    wr(8'h38, 0);
    cfg(12, 8'h62); cfg(20, 8'h62);
    cmd(20, 8'h4C); cmd(12, 8'h4C);
    rd(8'h10, 32'h100C, "R6 tie goes to lowest number");
    irqchk(0, "R7 tie partner blocked");
    wr(8'h38, 0);
    rd(8'h10, 32'h1014, "R6 tie partner after eoi");
    wr(8'h38, 0);
    for (int k = 0; k < 8; k++) cfg(30 + k, 8'h60 | k[7:0]);
    for (int k = 0; k < 8; k++) begin
      cmd(30 + k, 8'h4C);
      rd(8'h10, 32'h1000 + 30 + k, "R9 nested acknowledge");
    end
    irqchk(0, "R9 full stack no request");
    rd(8'h18, 37, "R9 status at deepest level");
    for (int k = 0; k < 8; k++) wr(8'h38, 0);
    rd(8'h18, 0, "R9 eight eoi reach idle");
    wr(8'h38, 0);
    rd(8'h10, 32'hDEAD, "R9 extra eoi harmless");
    wr(8'h00, 40); wr(8'h04, 8'h67); wr(8'h4C, 1);
    irqchk(0, "R2 disabled pending gives no request");
    rd(8'h24, 32'h100, "R3 pending word one");
    wr(8'h48, 1);
    cmd(100, 8'h4C);
    rd(8'h2C, 32'h10, "R3 pending word three");
    wr(8'h00, 50); wr(8'h04, 8'h21);
    tick(); src_i[50] = 0;
    rd(8'h24, 32'h40000, "R4 falling edge");
    wr(8'h48, 1);
    rd(8'h24, 0, "R4 edge sets only once");
    tick(); src_i[51] = 0;
    rd(8'h24, 32'h80000, "R4 level-low input");
    tick(); tick();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule